// File: doc/BRIEF.md
# Single-Cycle Sorted Insertion Register File

This block is a register file of `DEPTH` entries that always holds its contents in ascending order. A new value arrives with an insert strobe. Every cell compares its own contents with that value in the same cycle, and each cell then does one of three things:

- It holds its contents.
- It takes the value of its lower neighbour.
- It captures the new value.

Each cell decides this from its own comparator and the decision of the cell below it. No result ripples from one cell to the next. Insertion therefore finishes on a single clock edge at any depth.

Every cell drives a parallel output, with cell 0 holding the smallest value. Alongside the cells the block gives a per-cell valid mask, the number of stored entries and a full flag.

Empty cells count as larger than any incoming value. As a result, a new entry falls into the first free slot when it is the largest value seen so far. When the file is full, an insert is refused and the block pulses an error output.

Top module: `sorted_insert_regs`

## Requirements
- R1: While `rst` is high at a clock edge, all valid bits, `count`, `full` and `reject` clear by that edge.
- R2: One clock after an accepted insert, cells 0 to `count`-1 hold the stored values plus the new one in ascending order. Cell i is output on `cells[i*WIDTH +: WIDTH]`, and cell 0 holds the smallest value.
- R3: Equal values are all kept. Each duplicate occupies its own cell.
- R4: An accepted insert (`ins_en` high while `full` is low) raises `count` by exactly one.
- R5: `full` is high exactly when `count` equals `DEPTH`.
- R6: An insert while `full` is high changes no cell, no valid bit and not `count`. `reject` is high during the cycle that follows that edge and only then.
- R7: In a cycle without `ins_en`, the cells, the valid mask and `count` keep their values.
- R8: Bit i of `valid` is high exactly when i < `count`.
- R9: When `rst` and `ins_en` are high in the same cycle, the reset wins and the file ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_en | input | 1 | Insert strobe |
| ins_data | input | WIDTH | Unsigned value to insert |
| cells | output | DEPTH*WIDTH | Sorted contents, cell i at bits i*WIDTH +: WIDTH |
| valid | output | DEPTH | Per-cell occupancy mask |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| full | output | 1 | All cells occupied |
| reject | output | 1 | One-cycle pulse after a refused insert |

## Verification
Two things can land on the same edge:

- **Reset and insert.** The bench drives a strobe with a fresh value while `rst` is high. It then expects an empty file with a zero count and no reject pulse.
- **Full flag and insert.** The stimulus table holds more values than the file has cells, with duplicates among them. It therefore crosses the edge where the last cell fills and `full` rises, and then keeps inserting. Each of those later strobes must leave the contents identical to a reference model and must produce exactly one reject pulse.

// File: rtl/sorted_insert_regs.sv
module sorted_insert_regs #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ins_en,
  input  logic [WIDTH-1:0]       ins_data,
  output logic [DEPTH*WIDTH-1:0] cells,
  output logic [DEPTH-1:0]       valid,
  output logic [CW-1:0]          count,
  output logic                   full,
  output logic                   reject
);

  logic [WIDTH-1:0] mem      [DEPTH];
  logic [WIDTH-1:0] mem_nxt  [DEPTH];
  logic [DEPTH-1:0] vld, vld_nxt, above;
  logic [CW-1:0]    cnt;
  logic             rej_q;

  assign full  = (cnt == CW'(DEPTH));
  wire   take  = ins_en && !full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign above[g] = !vld[g] || (mem[g] > ins_data);
    if (g == 0) begin : g_bottom
      assign mem_nxt[g] = ins_data;
      assign vld_nxt[g] = 1'b1;
    end else begin : g_upper
      assign mem_nxt[g] = above[g-1] ? mem[g-1] : ins_data;
      assign vld_nxt[g] = vld[g-1];
    end
    assign cells[g*WIDTH +: WIDTH] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int i = 0; i < DEPTH; i++)
        if (above[i]) mem[i] <= mem_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      cnt   <= '0;
      rej_q <= 1'b0;
    end else begin
      rej_q <= ins_en && full;
      if (take) begin
        cnt <= cnt + 1'b1;
        for (int i = 0; i < DEPTH; i++)
          if (above[i]) vld[i] <= vld_nxt[i];
      end
    end
  end

  assign valid  = vld;
  assign count  = cnt;
  assign reject = rej_q;

endmodule

module sorted_insert_regs_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ins_en,
  input logic [DEPTH*WIDTH-1:0] cells,
  input logic [DEPTH-1:0]       valid,
  input logic [CW-1:0]          count,
  input logic                   full,
  input logic                   reject
);

  for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_ord
    assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
      valid[g+1] |-> cells[g*WIDTH +: WIDTH] <= cells[(g+1)*WIDTH +: WIDTH]);
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !full) |=> count == $past(count) + 1'b1);

  assert_refuse_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ins_en && full) |=> reject && $stable(cells) && $stable(valid) && $stable(count));

  assert_reject_cause_R6: assert property (@(posedge clk) disable iff (rst)
    reject |-> $past(ins_en && full));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ins_en |=> $stable(valid) && $stable(count));

  assert_mask_count_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(valid) == int'(count));

  assert_reset_wins_R9: assert property (@(posedge clk)
    rst |=> count == '0 && valid == '0 && !reject);

endmodule

bind sorted_insert_regs sorted_insert_regs_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .ins_en(ins_en), .cells(cells), .valid(valid),
  .count(count), .full(full), .reject(reject)
);

// File: tb/test_sorted_insert_regs.sv
module test_sorted_insert_regs;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 8;
  localparam int CW = $clog2(N + 1);
  localparam int NV = 12;
  localparam logic [W-1:0] VEC [NV] = '{8'd40, 8'd10, 8'd40, 8'd255, 8'd0, 8'd25,
                                        8'd10, 8'd99, 8'd5, 8'd40, 8'd0, 8'd200};

  logic clk = 0, rst = 1, ins_en = 0;
  logic [W-1:0] ins_data = '0;
  logic [N*W-1:0] cells;
  logic [N-1:0] valid;
  logic [CW-1:0] count;
  logic full, reject;

  int runs = 0, fails = 0;
  int mcnt = 0;
  logic [W-1:0] model [N];
  logic exp_rej = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sorted_insert_regs #(.WIDTH(W), .DEPTH(N)) i_sorted_insert_regs (
    .clk(clk), .rst(rst), .ins_en(ins_en), .ins_data(ins_data), .cells(cells),
    .valid(valid), .count(count), .full(full), .reject(reject));

  task automatic chk(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [N-1:0] em;
    chk({req, "/R4 count"}, int'(count), mcnt);
    chk({req, "/R5 full"}, int'(full), int'(mcnt == N));
    chk({req, "/R6 reject"}, int'(reject), int'(exp_rej));
    for (int i = 0; i < N; i++) em[i] = (i < mcnt);
    chk({req, "/R8 valid"}, int'(valid), int'(em));
    for (int i = 0; i < mcnt; i++)
      chk({req, "/R2 cell"}, int'(cells[i*W +: W]), int'(model[i]));
  endtask

  task automatic model_insert(logic [W-1:0] v);
    int p;
    if (mcnt == N) begin exp_rej = 1; return; end
    exp_rej = 0;
    p = 0;
    while (p < mcnt && model[p] <= v) p++;
    for (int i = mcnt; i > p; i--) model[i] = model[i-1];
    model[p] = v;
    mcnt++;
  endtask

  task automatic insert(logic [W-1:0] v, string req);
    @(negedge clk); ins_en = 1; ins_data = v;
    @(negedge clk); ins_en = 0;
    model_insert(v);
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ins_en = 0;
    @(negedge clk); rst = 0;
    mcnt = 0; exp_rej = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    compare("R1 reset");

    for (int k = 0; k < NV; k++) insert(VEC[k], "R2 R3 table");

    @(negedge clk);
    exp_rej = 0;
    compare("R7 idle after reject");

    @(negedge clk); rst = 1; ins_en = 1; ins_data = 8'd77;
    @(negedge clk); rst = 0; ins_en = 0;
    mcnt = 0; exp_rej = 0;
    compare("R9 reset with insert");
    compare("R1 reset");

    for (int s = 0; s < 20; s++) begin
      int len = 1 + $urandom_range(0, N + 2);
      do_reset();
      for (int k = 0; k < len; k++) insert(W'($urandom_range(0, 7)), "R3 random dup");
      @(negedge clk); exp_rej = 0;
      compare("R7 random hold");
    end

    do_reset();
    for (int k = 0; k < N; k++) insert(8'd9, "R3 all equal");
    insert(8'd1, "R6 full reject");
    @(negedge clk); exp_rej = 0;
    compare("R6 pulse ends");

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule